// File: doc/BRIEF.md
# Burst-Window Register Access Redirector

This block sits in a peripheral's register file, between a word-addressed register bus and the peripheral's register array. A DMA engine can then move a run of neighbouring control registers while it only ever addresses one fixed word, the data port. A burst-control register holds two fields: a starting register offset and a burst length. Each read or write that hits the data port is sent on to the register at the starting offset plus a hardware-kept index. After that access the index steps forward, and it returns to zero once the burst is complete.

The redirect path is combinational. The target address, the strobes and the read data belong to the same cycle as the bus access. The index and the burst-control register change at the clock edge that closes the access. Accesses to any other address go straight through to the register array unchanged. The burst-control register itself is held inside this block.

Top module: `burst_redirector`

## Requirements
- R1: The burst-control register sits at word address CTRL_ADDR (default 18). Its length field is bits 12:8 and its starting-offset field is bits 4:0. It resets to 0x0000, and a read returns the stored fields.
- R2: Bits 15:13 and 7:5 of the burst-control register always read as zero. Writes to those bits have no effect.
- R3: A read or write at the data port PORT_ADDR (default 19) is sent to word address REG_BASE + offset + index (a byte address of 4× that value). On a write, the write data passes through. On a read, the register array's data is returned.
- R4: Each in-range or out-of-range read or write at the data port counts as one transfer and advances the index by one.
- R5: The access made with index equal to the length field is the last of the burst. The index then returns to 0, so a burst has length+1 transfers, and a length of 0 makes every access hit the starting offset.
- R6: Writing the burst-control register clears the index to 0.
- R7: If offset + index is NUM_REGS (default 18) or more, no target strobe is raised. A read returns zero, a write is dropped, and the index still advances.
- R8: An access to any other address is forwarded with its own address, strobes and data, and it leaves the index unchanged. Idle cycles also leave the index unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Word address of the bus access |
| bus_we | input | 1 | Write enable |
| bus_re | input | 1 | Read enable |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, zero when no read is made |
| tgt_addr | output | ADDR_W | Word address sent to the register array |
| tgt_we | output | 1 | Write strobe to the register array |
| tgt_re | output | 1 | Read strobe to the register array |
| tgt_wdata | output | 16 | Write data to the register array |
| tgt_rdata | input | 16 | Read data from the register array, same cycle |

## Verification
Target address, strobes and bus read data are due in the same cycle as the access. The bench drives each access at a falling edge and samples these outputs 2 ns later, before the next rising edge. Index and control-register changes take effect at that rising edge, so they are observed only through the next access's target address or a read-back one cycle later. The bench's register-array model commits writes at the same edge, which means a value written in one access is expected back on the following access.

// File: rtl/burst_pkg.sv
package burst_pkg;

    localparam int WORD_W = 16;
    localparam int FLD_W  = 5;
    localparam int LEN_LSB = 8;

    typedef struct packed {
        logic [FLD_W-1:0] len;
        logic [FLD_W-1:0] base;
    } burst_cfg_t;

    typedef enum logic [1:0] {
        ACC_IDLE,
        ACC_CTRL,
        ACC_PORT,
        ACC_PASS
    } acc_kind_t;

    function automatic burst_cfg_t cfg_unpack(input logic [WORD_W-1:0] w);
        burst_cfg_t c;
        c.len  = w[LEN_LSB +: FLD_W];
        c.base = w[0 +: FLD_W];
        return c;
    endfunction

    function automatic logic [WORD_W-1:0] cfg_pack(input burst_cfg_t c);
        logic [WORD_W-1:0] w;
        w = '0;
        w[LEN_LSB +: FLD_W] = c.len;
        w[0 +: FLD_W]       = c.base;
        return w;
    endfunction

endpackage

// File: rtl/burst_cfg_reg.sv
module burst_cfg_reg
    import burst_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [WORD_W-1:0] wr_data,
    output burst_cfg_t        cfg
);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg <= '0;
        end else if (wr_en) begin
            cfg <= cfg_unpack(wr_data);
        end
    end

endmodule

// File: rtl/burst_index.sv
module burst_index
    import burst_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             step,
    input  logic [FLD_W-1:0] len,
    output logic [FLD_W-1:0] idx
);

    logic last;
    assign last = (idx == len);

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            idx <= '0;
        end else if (step) begin
            idx <= last ? '0 : idx + 1'b1;
        end
    end

    AST_IDX_STEP: assert property (@(posedge clk) disable iff (rst)
        (step && !clr && idx != len) |=> idx == FLD_W'($past(idx) + 1'b1)); // R4
    AST_IDX_WRAP: assert property (@(posedge clk) disable iff (rst)
        (step && !clr && idx == len) |=> idx == '0); // R5
    AST_IDX_CLEAR: assert property (@(posedge clk) disable iff (rst)
        clr |=> idx == '0); // R6
    AST_IDX_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!step && !clr) |=> $stable(idx)); // R8

endmodule

// File: rtl/burst_route.sv
module burst_route
    import burst_pkg::*;
#(
    parameter int ADDR_W    = 6,
    parameter int NUM_REGS  = 18,
    parameter int REG_BASE  = 0,
    parameter int CTRL_ADDR = 18,
    parameter int PORT_ADDR = 19
) (
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic              bus_re,
    input  logic [WORD_W-1:0] bus_wdata,
    output logic [WORD_W-1:0] bus_rdata,
    input  burst_cfg_t        cfg,
    input  logic [FLD_W-1:0]  idx,
    output acc_kind_t         kind,
    output logic [ADDR_W-1:0] tgt_addr,
    output logic              tgt_we,
    output logic              tgt_re,
    output logic [WORD_W-1:0] tgt_wdata,
    input  logic [WORD_W-1:0] tgt_rdata
);

    localparam int SUM_W = ADDR_W + 1;

    logic [SUM_W-1:0] win_off;
    logic [SUM_W-1:0] win_addr;
    logic             in_range;

    assign win_off  = SUM_W'(cfg.base) + SUM_W'(idx);
    assign win_addr = win_off + SUM_W'(REG_BASE);
    assign in_range = win_off < SUM_W'(NUM_REGS);

    always_comb begin
        if (!(bus_we || bus_re))                   kind = ACC_IDLE;
        else if (bus_addr == ADDR_W'(CTRL_ADDR))   kind = ACC_CTRL;
        else if (bus_addr == ADDR_W'(PORT_ADDR))   kind = ACC_PORT;
        else                                       kind = ACC_PASS;
    end

    always_comb begin
        tgt_addr  = bus_addr;
        tgt_we    = 1'b0;
        tgt_re    = 1'b0;
        tgt_wdata = bus_wdata;
        bus_rdata = '0;
        unique case (kind)
            ACC_PORT: begin
                tgt_addr = win_addr[ADDR_W-1:0];
                tgt_we   = bus_we && in_range;
                tgt_re   = bus_re && in_range;
                if (bus_re && in_range) bus_rdata = tgt_rdata;
            end
            ACC_PASS: begin
                tgt_we = bus_we;
                tgt_re = bus_re;
                if (bus_re) bus_rdata = tgt_rdata;
            end
            ACC_CTRL: begin
                if (bus_re) bus_rdata = cfg_pack(cfg);
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/burst_redirector.sv
module burst_redirector
    import burst_pkg::*;
#(
    parameter int ADDR_W    = 6,
    parameter int NUM_REGS  = 18,
    parameter int REG_BASE  = 0,
    parameter int CTRL_ADDR = 18,
    parameter int PORT_ADDR = 19
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic              bus_re,
    input  logic [15:0]       bus_wdata,
    output logic [15:0]       bus_rdata,
    output logic [ADDR_W-1:0] tgt_addr,
    output logic              tgt_we,
    output logic              tgt_re,
    output logic [15:0]       tgt_wdata,
    input  logic [15:0]       tgt_rdata
);

    burst_cfg_t       cfg;
    logic [FLD_W-1:0] idx;
    acc_kind_t        kind;
    logic             cfg_wr;
    logic             port_hit;

    assign cfg_wr   = (kind == ACC_CTRL) && bus_we;
    assign port_hit = (kind == ACC_PORT);

    burst_cfg_reg u_cfg (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (cfg_wr),
        .wr_data (bus_wdata),
        .cfg     (cfg)
    );

    burst_index u_idx (
        .clk  (clk),
        .rst  (rst),
        .clr  (cfg_wr),
        .step (port_hit),
        .len  (cfg.len),
        .idx  (idx)
    );

    burst_route #(
        .ADDR_W    (ADDR_W),
        .NUM_REGS  (NUM_REGS),
        .REG_BASE  (REG_BASE),
        .CTRL_ADDR (CTRL_ADDR),
        .PORT_ADDR (PORT_ADDR)
    ) u_route (
        .bus_addr  (bus_addr),
        .bus_we    (bus_we),
        .bus_re    (bus_re),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .cfg       (cfg),
        .idx       (idx),
        .kind      (kind),
        .tgt_addr  (tgt_addr),
        .tgt_we    (tgt_we),
        .tgt_re    (tgt_re),
        .tgt_wdata (tgt_wdata),
        .tgt_rdata (tgt_rdata)
    );

    logic beyond_window;
    assign beyond_window = (int'(cfg.base) + int'(idx)) >= NUM_REGS;

    AST_OOR_DROP: assert property (@(posedge clk) disable iff (rst)
        (bus_addr == ADDR_W'(PORT_ADDR) && beyond_window)
            |-> (!tgt_we && !tgt_re && bus_rdata == '0)); // R7
    AST_RSV_ZERO: assert property (@(posedge clk) disable iff (rst)
        (bus_re && bus_addr == ADDR_W'(CTRL_ADDR))
            |-> (bus_rdata[15:13] == '0 && bus_rdata[7:5] == '0)); // R2
    AST_PASS_THRU: assert property (@(posedge clk) disable iff (rst)
        (bus_addr != ADDR_W'(CTRL_ADDR) && bus_addr != ADDR_W'(PORT_ADDR))
            |-> (tgt_addr == bus_addr && tgt_we == bus_we && tgt_re == bus_re)); // R8

endmodule

// File: tb/sim_burst_redirector.sv
module sim_burst_redirector;

    localparam int ADDR_W    = 6;
    localparam int NUM_REGS  = 18;
    localparam int CTRL      = 18;
    localparam int PORT      = 19;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic              bus_we = 1'b0;
    logic              bus_re = 1'b0;
    logic [15:0]       bus_wdata = '0;
    logic [15:0]       bus_rdata;
    logic [ADDR_W-1:0] tgt_addr;
    logic              tgt_we;
    logic              tgt_re;
    logic [15:0]       tgt_wdata;
    logic [15:0]       tgt_rdata;

    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    burst_redirector u0 (
        .clk(clk), .rst(rst),
        .bus_addr(bus_addr), .bus_we(bus_we), .bus_re(bus_re),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .tgt_addr(tgt_addr), .tgt_we(tgt_we), .tgt_re(tgt_re),
        .tgt_wdata(tgt_wdata), .tgt_rdata(tgt_rdata)
    );

    // register array model
    logic [15:0] mem [NUM_REGS];
    assign tgt_rdata = (int'(tgt_addr) < NUM_REGS) ? mem[tgt_addr] : 16'h0;
    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NUM_REGS; i++) mem[i] <= '0;
        end else if (tgt_we && int'(tgt_addr) < NUM_REGS) begin
            mem[tgt_addr] <= tgt_wdata;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    task automatic drive(input int a, input logic we, input logic re, input logic [15:0] d);
        @(negedge clk);
        bus_addr  = ADDR_W'(a);
        bus_we    = we;
        bus_re    = re;
        bus_wdata = d;
        #2;
    endtask

    task automatic idle();
        @(negedge clk);
        bus_we = 1'b0;
        bus_re = 1'b0;
    endtask

    // {addr6, we, re, wdata16, exp_rdata16, exp_taddr6, exp_twe, exp_tre, req4}
    localparam int NV = 13;
    localparam logic [51:0] VEC [NV] = '{
        {6'd18, 1'b1, 1'b0, 16'h0203, 16'h0000, 6'd18, 1'b0, 1'b0, 4'd1}, // R1 len2 base3
        {6'd19, 1'b1, 1'b0, 16'h1111, 16'h0000, 6'd3,  1'b1, 1'b0, 4'd3}, // R3
        {6'd19, 1'b1, 1'b0, 16'h2222, 16'h0000, 6'd4,  1'b1, 1'b0, 4'd4}, // R4
        {6'd19, 1'b1, 1'b0, 16'h3333, 16'h0000, 6'd5,  1'b1, 1'b0, 4'd4},
        {6'd19, 1'b1, 1'b0, 16'h4444, 16'h0000, 6'd3,  1'b1, 1'b0, 4'd5}, // R5 wrap
        {6'd3,  1'b0, 1'b1, 16'h0000, 16'h4444, 6'd3,  1'b0, 1'b1, 4'd8}, // R8
        {6'd19, 1'b0, 1'b1, 16'h0000, 16'h2222, 6'd4,  1'b0, 1'b1, 4'd4},
        {6'd5,  1'b0, 1'b1, 16'h0000, 16'h3333, 6'd5,  1'b0, 1'b1, 4'd8},
        {6'd19, 1'b0, 1'b1, 16'h0000, 16'h3333, 6'd5,  1'b0, 1'b1, 4'd8},
        {6'd19, 1'b0, 1'b1, 16'h0000, 16'h4444, 6'd3,  1'b0, 1'b1, 4'd5},
        {6'd18, 1'b0, 1'b1, 16'h0000, 16'h0203, 6'd18, 1'b0, 1'b0, 4'd1},
        {6'd18, 1'b1, 1'b0, 16'hFFFF, 16'h0000, 6'd18, 1'b0, 1'b0, 4'd2}, // R2
        {6'd18, 1'b0, 1'b1, 16'h0000, 16'h1F1F, 6'd18, 1'b0, 1'b0, 4'd2}
    };

    task automatic run_all();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // reset state
        drive(CTRL, 1'b0, 1'b1, 16'h0);
        chk("R1 reset ctrl", bus_rdata, 16'h0000);
        drive(PORT, 1'b0, 1'b1, 16'h0);
        chk("R3 reset port addr", tgt_addr, 0);
        chk("R3 reset port data", bus_rdata, 16'h0000);

        // vector table
        for (int v = 0; v < NV; v++) begin
            string tag;
            drive(int'(VEC[v][51:46]), VEC[v][45], VEC[v][44], VEC[v][43:28]);
            tag = $sformatf("R%0d row%0d", VEC[v][3:0], v);
            chk({tag, " rdata"}, bus_rdata, VEC[v][27:12]);
            chk({tag, " taddr"}, tgt_addr, VEC[v][11:6]);
            chk({tag, " twe"}, tgt_we, VEC[v][5]);
            chk({tag, " tre"}, tgt_re, VEC[v][4]);
        end

        // out of range window: len3 base16
        drive(CTRL, 1'b1, 1'b0, 16'h0310);
        drive(PORT, 1'b1, 1'b0, 16'hAAAA);
        chk("R7 in-range addr", tgt_addr, 16);
        chk("R7 in-range we", tgt_we, 1);
        drive(PORT, 1'b1, 1'b0, 16'hBBBB);
        chk("R7 last reg we", tgt_we, 1);
        drive(PORT, 1'b1, 1'b0, 16'hCCCC);
        chk("R7 oor write dropped", tgt_we, 0);
        drive(PORT, 1'b0, 1'b1, 16'h0);
        chk("R7 oor read strobe", tgt_re, 0);
        chk("R7 oor read zero", bus_rdata, 16'h0000);
        drive(PORT, 1'b0, 1'b1, 16'h0);
        chk("R7 index advanced then wrap", tgt_addr, 16);
        chk("R5 wrap read data", bus_rdata, 16'hAAAA);
        drive(17, 1'b0, 1'b1, 16'h0);
        chk("R8 direct read reg17", bus_rdata, 16'hBBBB);
        drive(CTRL, 1'b0, 1'b1, 16'h0);
        chk("R7 ctrl untouched by dropped write", bus_rdata, 16'h0310);

        // index clear on ctrl write, idle holds index
        drive(CTRL, 1'b1, 1'b0, 16'h0400);
        drive(PORT, 1'b0, 1'b1, 16'h0);
        drive(PORT, 1'b0, 1'b1, 16'h0);
        chk("R4 second step", tgt_addr, 1);
        idle();
        idle();
        drive(PORT, 1'b0, 1'b1, 16'h0);
        chk("R8 idle holds index", tgt_addr, 2);
        drive(CTRL, 1'b1, 1'b0, 16'h0400);
        drive(PORT, 1'b0, 1'b1, 16'h0);
        chk("R6 ctrl write clears index", tgt_addr, 0);

        // length zero: every access hits base
        drive(CTRL, 1'b1, 1'b0, 16'h0007);
        drive(PORT, 1'b0, 1'b1, 16'h0);
        drive(PORT, 1'b0, 1'b1, 16'h0);
        chk("R5 len0 stays at base", tgt_addr, 7);
        idle();
    endtask

    initial begin
        fork
            run_all();
            begin
                #1_000_000;
                fails++;
                checks++;
                $display("FAIL watchdog all-reqs act=timeout exp=done");
            end
        join_any
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule